// File: doc/BRIEF.md
# Scatter Descriptor Table Builder

This block turns the list of physical buffer segments of one transfer into a table of 8-byte region descriptors. It writes that table into a local descriptor RAM, which a DMA engine then walks. Segments arrive one at a time, each with a byte address, a byte length and a flag that marks the final segment.

A segment that starts exactly where the open region ends is folded into that region. Any other segment closes the open region, and the closed region is written out. Each region is cut into chunks so that no descriptor reaches past a 64 KiB address line. After the last chunk is written, the block sets the end-of-table flag in the final descriptor by reading back its count word and writing it again.

At the end of each transfer the block pulses `done` once. The pulse carries the number of descriptors written, or an error code:

- a misaligned segment address,
- a table overflow,
- an empty table.

On any error code the requester drops DMA for that transfer and uses programmed I/O instead.

Top module: `sg_desc_builder`

## Requirements
- R1: After reset `done` is low and `seg_ready` is high.
- R2: Descriptor k occupies RAM words 2k and 2k+1. Word 2k is the 32-bit start address. Bits 15:0 of word 2k+1 are the byte count and bits 30:16 are zero. `rd_data` returns the word at `rd_idx` one clock after `rd_idx` is presented.
- R3: Each chunk is the smaller of the bytes left in the region and 0x10000 minus (address AND 0xFFFF). A chunk of exactly 0x10000 bytes is encoded as count 0.
- R4: A segment whose address equals the open region's start plus its size (the size being non-zero) is merged into that region before any splitting.
- R5: A segment that is not contiguous with the open region closes that region, and its own descriptors start a new entry.
- R6: Bit 31 of word 2k+1 is 1 for the last descriptor of a successful transfer and 0 for every other descriptor.
- R7: Exactly one one-cycle `done` pulse follows the last segment of a transfer. On success `done_err` is 0 and `done_count` is the number of descriptors.
- R8: A segment with a non-zero address[1:0] aborts the build with `done_err` = 1 and `done_count` = 0. Later segments up to and including the one flagged last are accepted and discarded, and only then does `done` pulse.
- R9: A transfer that needs more than MAX_DESC descriptors ends with `done_err` = 2 and `done_count` = 0. Exactly MAX_DESC descriptors is a success.
- R10: A transfer that yields no descriptors (all lengths zero) ends with `done_err` = 3 and `done_count` = 0.
- R11: Every transfer starts with an empty table: it is never merged with the previous transfer's region, and its first descriptor is entry 0, also after an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Block takes a segment this cycle |
| seg_addr | input | 32 | Segment physical byte address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the transfer |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_count | output | $clog2(MAX_DESC+1) | Descriptors written (0 on error) |
| done_err | output | 2 | 0 ok, 1 misaligned, 2 overflow, 3 empty |
| rd_idx | input | $clog2(2*MAX_DESC) | Descriptor RAM word index |
| rd_data | output | 32 | Registered descriptor RAM word |

## Verification
The hardest situation to reach is a closing region that runs the table full while a non-contiguous segment is parked in the pending slot. In that case the pending segment must be dropped and the rest of the transfer drained. A second hard case is a region that ends exactly at capacity: the end-of-table update must then land on entry MAX_DESC-1. The bench builds the design with a capacity of eight and uses segment lengths of several 64 KiB units, so a few segments reach both edges. Around that it sweeps start offsets across a 64 KiB line, with lengths that split into one, two or three chunks, and compares every written word with an arithmetic model.

// File: rtl/sg_desc_builder.sv
module sg_desc_builder #(
  parameter int LEN_W    = 20,
  parameter int MAX_DESC = 256,
  localparam int CNT_W   = $clog2(MAX_DESC + 1),
  localparam int WA_W    = $clog2(2 * MAX_DESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             seg_last,
  output logic             done,
  output logic [CNT_W-1:0] done_count,
  output logic [1:0]       done_err,
  input  logic [WA_W-1:0]  rd_idx,
  output logic [31:0]      rd_data
);

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_MIS   = 2'd1;
  localparam logic [1:0] ERR_OVF   = 2'd2;
  localparam logic [1:0] ERR_EMPTY = 2'd3;

  typedef enum logic [2:0] {
    S_COLLECT, S_EMIT_A, S_EMIT_C, S_EOT_RD, S_EOT_WR, S_DONE, S_DRAIN
  } state_t;

  state_t           state;
  logic [31:0]      cur_addr;
  logic [32:0]      cur_size;
  logic [31:0]      pend_addr;
  logic [LEN_W-1:0] pend_len;
  logic             pend_v;
  logic             fin;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       err;
  logic [16:0]      chunk;
  logic [31:0]      rmw_q;
  logic [31:0]      mem [2*MAX_DESC];

  logic             accept, misal, contig, full;
  logic [16:0]      room, next_chunk;
  logic             we;
  logic [WA_W-1:0]  wa, last_cw;
  logic [31:0]      wd;

  assign seg_ready  = (state == S_COLLECT) || (state == S_DRAIN);
  assign accept     = seg_valid && seg_ready;
  assign misal      = |seg_addr[1:0];
  assign contig     = (cur_size != '0) && (seg_addr == cur_addr + cur_size[31:0]);
  assign room       = 17'h10000 - {1'b0, cur_addr[15:0]};
  assign next_chunk = (cur_size < {16'b0, room}) ? cur_size[16:0] : room;
  assign full       = (cnt == CNT_W'(MAX_DESC));
  assign last_cw    = WA_W'({cnt - 1'b1, 1'b1});

  assign done       = (state == S_DONE);
  assign done_err   = err;
  assign done_count = (err == ERR_NONE) ? cnt : '0;

  always_comb begin
    we = 1'b0;
    wa = '0;
    wd = '0;
    case (state)
      S_EMIT_A: begin
        we = (cur_size != '0) && !full;
        wa = WA_W'({cnt, 1'b0});
        wd = cur_addr;
      end
      S_EMIT_C: begin
        we = 1'b1;
        wa = WA_W'({cnt, 1'b1});
        wd = {16'b0, chunk[15:0]};
      end
      S_EOT_WR: begin
        we = 1'b1;
        wa = last_cw;
        wd = rmw_q | 32'h8000_0000;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rmw_q   <= mem[last_cw];
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_COLLECT;
      cur_addr  <= '0;
      cur_size  <= '0;
      pend_addr <= '0;
      pend_len  <= '0;
      pend_v    <= 1'b0;
      fin       <= 1'b0;
      cnt       <= '0;
      err       <= ERR_NONE;
      chunk     <= '0;
    end else begin
      case (state)
        S_COLLECT: if (accept) begin
          if (misal) begin
            err   <= ERR_MIS;
            state <= seg_last ? S_DONE : S_DRAIN;
          end else if (contig) begin
            cur_size <= cur_size + 33'(seg_len);
            if (seg_last) begin
              fin   <= 1'b1;
              state <= S_EMIT_A;
            end
          end else if (cur_size != '0) begin
            pend_addr <= seg_addr;
            pend_len  <= seg_len;
            pend_v    <= 1'b1;
            fin       <= seg_last;
            state     <= S_EMIT_A;
          end else begin
            cur_addr <= seg_addr;
            cur_size <= 33'(seg_len);
            if (seg_last) begin
              fin   <= 1'b1;
              state <= S_EMIT_A;
            end
          end
        end
        S_EMIT_A: begin
          if (cur_size == '0) begin
            if (pend_v) begin
              cur_addr <= pend_addr;
              cur_size <= 33'(pend_len);
              pend_v   <= 1'b0;
              if (!fin) state <= S_COLLECT;
            end else if (fin) begin
              if (cnt == '0) begin
                err   <= ERR_EMPTY;
                state <= S_DONE;
              end else begin
                state <= S_EOT_RD;
              end
            end else begin
              state <= S_COLLECT;
            end
          end else if (full) begin
            err   <= ERR_OVF;
            state <= fin ? S_DONE : S_DRAIN;
          end else begin
            chunk <= next_chunk;
            state <= S_EMIT_C;
          end
        end
        S_EMIT_C: begin
          cur_addr <= cur_addr + 32'(chunk);
          cur_size <= cur_size - 33'(chunk);
          cnt      <= cnt + 1'b1;
          state    <= S_EMIT_A;
        end
        S_EOT_RD: state <= S_EOT_WR;
        S_EOT_WR: state <= S_DONE;
        S_DONE: begin
          cur_size <= '0;
          pend_v   <= 1'b0;
          fin      <= 1'b0;
          cnt      <= '0;
          err      <= ERR_NONE;
          state    <= S_COLLECT;
        end
        S_DRAIN: if (accept && seg_last) state <= S_DONE;
        default: state <= S_COLLECT;
      endcase
    end
  end

  // R3
  boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EMIT_C) |-> ((chunk != '0) &&
      (({2'b0, cur_addr[15:0]} + {1'b0, chunk}) <= 18'h10000)));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_DESC));

  // R7
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  nonempty_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err == ERR_NONE) |-> (done_count != '0));

  // R8
  misalign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COLLECT && accept && misal) |=> (done_err == ERR_MIS));

endmodule

// File: tb/test_sg_desc_builder.sv
`timescale 1ns/1ps
module test_sg_desc_builder;
  localparam int MAXD = 8;
  localparam int LW   = 20;
  localparam int CW   = $clog2(MAXD + 1);
  localparam int AW   = $clog2(2 * MAXD);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          seg_valid = 1'b0;
  logic          seg_ready;
  logic [31:0]   seg_addr = '0;
  logic [LW-1:0] seg_len = '0;
  logic          seg_last = 1'b0;
  logic          done;
  logic [CW-1:0] done_count;
  logic [1:0]    done_err;
  logic [AW-1:0] rd_idx = '0;
  logic [31:0]   rd_data;

  sg_desc_builder #(.LEN_W(LW), .MAX_DESC(MAXD)) i_sg_desc_builder (
    .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .done(done), .done_count(done_count), .done_err(done_err),
    .rd_idx(rd_idx), .rd_data(rd_data));

  int total = 0;
  int bad   = 0;

  logic [31:0] sa [16];
  longint      sl [16];
  int          ns;
  longint      ea [MAXD];
  longint      ec [MAXD];
  int          en;
  int          eerr;

  int            npulse = 0;
  logic [CW-1:0] gcnt;
  logic [1:0]    gerr;
  always @(negedge clk) if (done) begin
    npulse <= npulse + 1;
    gcnt   <= done_count;
    gerr   <= done_err;
  end

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic emit(inout longint a, inout longint s);
    longint room, c;
    while (s > 0 && eerr == 0) begin
      if (en == MAXD) begin
        eerr = 2;
        break;
      end
      room = 65536 - (a % 65536);
      c = (s < room) ? s : room;
      ea[en] = a;
      ec[en] = c % 65536;
      en++;
      a += c;
      s -= c;
    end
  endtask

  task automatic model();
    longint ra, rs;
    ra = 0; rs = 0; en = 0; eerr = 0;
    for (int i = 0; i < ns; i++) begin
      if (eerr != 0) continue;
      if (sa[i][1:0] != 2'b00) begin
        eerr = 1;
        continue;
      end
      if (rs != 0 && longint'(sa[i]) == ra + rs) rs += sl[i];
      else begin
        emit(ra, rs);
        ra = longint'(sa[i]);
        rs = sl[i];
      end
    end
    if (eerr == 0) emit(ra, rs);
    if (eerr == 0 && en == 0) eerr = 3;
  endtask

  task automatic rdw(int idx, output logic [31:0] v);
    @(negedge clk) rd_idx = AW'(idx);
    @(negedge clk) v = rd_data;
  endtask

  task automatic run(string req);
    int p0;
    logic [31:0] w;
    longint eot;
    model();
    p0 = npulse;
    for (int i = 0; i < ns; i++) begin
      @(negedge clk);
      seg_valid = 1'b1;
      seg_addr  = sa[i];
      seg_len   = LW'(sl[i]);
      seg_last  = (i == ns - 1);
      while (!seg_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    seg_valid = 1'b0;
    seg_last  = 1'b0;
    wait (npulse != p0);
    repeat (3) @(negedge clk);
    chk({req, " R7 pulses"}, npulse - p0, 1);
    chk({req, " err"}, gerr, eerr);
    chk({req, " count"}, gcnt, (eerr == 0) ? en : 0);
    chk({req, " R11 ready"}, seg_ready, 1);
    if (eerr == 0 && gerr == 2'd0) begin
      for (int k = 0; k < en; k++) begin
        rdw(2 * k, w);
        chk({req, " R2 addr"}, w, ea[k]);
        rdw(2 * k + 1, w);
        eot = (k == en - 1) ? 64'h8000_0000 : 64'h0;
        chk({req, " R6 count word"}, w, ec[k] | eot);
      end
    end
  endtask

  task automatic s1(logic [31:0] a, longint l);
    ns = 1; sa[0] = a; sl[0] = l;
  endtask

  task automatic s2(logic [31:0] a0, longint l0, logic [31:0] a1, longint l1);
    ns = 2; sa[0] = a0; sl[0] = l0; sa[1] = a1; sl[1] = l1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint lens [4];
    lens[0] = 4; lens[1] = 'h40; lens[2] = 'h10000; lens[3] = 'h1fffc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 ready", seg_ready, 1);

    s1(32'h1000, 'h200);                         run("R2 single");
    s2(32'h2000, 'h100, 32'h2100, 'h300);        run("R4 merge");
    ns = 3; sa[0] = 32'h3000; sl[0] = 'h40; sa[1] = 32'h3100; sl[1] = 'h40;
    sa[2] = 32'h3040; sl[2] = 'h20;              run("R5 separate");
    s1(32'hff00, 'h200);                         run("R3 split");
    s1(32'h20000, 'h10000);                      run("R3 full 64k");
    s1(32'h30000, 'h20000);                      run("R3 two full");
    s2(32'h1fff0, 'h8, 32'h1fff8, 'h10);         run("R4 merge then split");

    s1(32'h1002, 'h40);                          run("R8 misaligned only");
    ns = 3; sa[0] = 32'h4000; sl[0] = 'h100; sa[1] = 32'h4101; sl[1] = 'h10;
    sa[2] = 32'h5000; sl[2] = 'h10;              run("R8 misaligned drain");
    s1(32'h6000, 'h80);                          run("R11 after error");

    s1(32'h0, 'h90000);                          run("R9 overflow");
    s1(32'h0, 'h80000);                          run("R9 exact capacity");
    ns = 10;
    for (int i = 0; i < 10; i++) begin
      sa[i] = 32'(i * 'h100); sl[i] = 4;
    end
    sl[1] = 'h70000;                             run("R9 overflow pending");
    s1(32'h7000, 'h100);                         run("R11 after overflow");

    s2(32'h8000, 0, 32'h9000, 0);                run("R10 empty");
    s1(32'h5000, 'h100);                         run("R11 first");
    s1(32'h5100, 'h100);                         run("R11 no cross merge");

    for (int k = 0; k < 16; k++)
      for (int j = 0; j < 4; j++) begin
        s1(32'hffc0 + 32'(8 * k), lens[j]);      run("R3 sweep");
      end
    for (int g = 0; g < 3; g++)
      for (int k = 0; k < 8; k++) begin
        s2(32'h2fff0 + 32'(4 * k), 'h20, 32'h2fff0 + 32'(4 * k) + 'h20 + 32'(4 * g), 'h10);
        run("R4 R5 sweep");
      end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule